// File: doc/BRIEF.md
# PLL bring-up control sequencer

This block brings a frequency synthesizer into service from a single start request. It takes an input divider M, a feedback divider N, a post-divider exponent P and a charge-pump setting. It then drives the synthesizer's base and auxiliary control words in a fixed, glitch-safe order. The loop stays bypassed until it is enabled. Only after that is the bypass removed. A stabilization interval, counted in ticks of a 1 MHz strobe, must then elapse before the block raises `ready`.

The block owns the base control word, which holds an "override" flag. When that flag is already set, a new request does not reprogram the synthesizer. Instead the request is compared against the current setting. A match reports "already correct". A mismatch reports an error and latches a sticky invalid flag. The block also reports, at all times, the nominal output frequency implied by the base word: Fin·N/(M·2^P), in kHz.

Top module: `synth_bringup_seq`

## Requirements
- R1: After reset, `base_ctl` is 0, `misc_ctl` equals MISC_INIT (0x90F by default), `busy`, `ready`, `invalid` are 0, `status` is 0 and `freq_khz` is 0.
- R2: A start accepted while idle with the override bit (base bit 18) clear writes, at that clock edge, M into base bits [4:0], N into [14:5] and P into [17:15], and sets override (bit 18) and bypass (bit 20), with enable (bit 19) clear.
- R3: One cycle after R2, the charge-pump value is written into misc bits [7:4], and every other misc bit keeps its value throughout.
- R4: One cycle after R3, enable (bit 19) is set while bypass stays set; one cycle later bypass is cleared.
- R5: `ready` drops when a fresh programming starts. It rises, with `status` = 0 (newly programmed), on the STABLE_US-th `tick_us` pulse counted after the edge that clears bypass.
- R6: `freq_khz` always equals FIN_KHZ·N/(M·2^P) of the current base fields, truncated, and is 0 when M = 0 (e.g. 12000 kHz, N=432, M=12, P=1 gives 216000).
- R7: A start while idle with override set, whose M, N and P equal the base fields with enable set, and with `invalid` clear, leaves base and misc unchanged and sets `status` to 1 (already correct) at that edge.
- R8: A start while idle with override set that does not match sets `status` to 2 and `invalid` to 1 and leaves base unchanged; `invalid` stays set until reset, so later matching requests also give status 2.
- R9: A start while a sequence is running is ignored: the base fields and the sequence are unaffected.
- R10: `busy` is high from the edge that accepts a fresh start until the edge where `ready` rises, and is never high for an override check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| start | input | 1 | Request to bring the synthesizer up |
| req_m | input | M_W | Requested input divider |
| req_n | input | N_W | Requested feedback divider |
| req_p | input | P_W | Requested post-divider exponent |
| req_cp | input | CP_W | Requested charge-pump setting |
| base_ctl | output | BASE_W | Synthesizer base control word (M, N, P, override, enable, bypass) |
| misc_ctl | output | MISC_W | Synthesizer auxiliary control word |
| freq_khz | output | FREQ_W | Nominal output frequency in kHz |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Output stable and usable |
| status | output | 2 | 0 fresh, 1 already correct, 2 override mismatch |
| invalid | output | 1 | Sticky mismatch flag |

## Verification
Fresh programming is tried with three divider sets: a P of 1, a P of 2 with a non-integer quotient, and an M of zero. Between them they separate the frequency arithmetic, the truncation and the zero guard. After programming, a repeat of the same request, a request with a different N, and then a repeat of the matching request tell the already-correct path apart from the mismatch path and from the stickiness of the invalid flag. A start injected during the stabilization wait shows that busy requests are ignored. An irregular tick pattern against the reference model fixes the exact cycle at which ready rises.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MISC,
        S_EN,
        S_UNBYP,
        S_WAIT
    } seq_state_e;

    localparam logic [1:0] ST_FRESH = 2'd0;
    localparam logic [1:0] ST_MATCH = 2'd1;
    localparam logic [1:0] ST_BAD   = 2'd2;

endpackage

// File: rtl/synth_stable_timer.sv
module synth_stable_timer #(
    parameter int unsigned LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign done_o = tmr_q.active && tick_i && (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = '0;
        end else if (done_o) begin
            tmr_d.active = 1'b0;
            tmr_d.cnt    = '0;
        end else if (tmr_q.active && tick_i) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.active <= 1'b0;
            tmr_q.cnt    <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R5: the count never passes the programmed stabilization length
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R5: an idle timer holds its count at zero
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_q.active |-> (tmr_q.cnt == '0));

endmodule

// File: rtl/synth_freq_calc.sv
module synth_freq_calc #(
    parameter int unsigned M_W     = 5,
    parameter int unsigned N_W     = 10,
    parameter int unsigned P_W     = 3,
    parameter int unsigned FIN_KHZ = 12000,
    parameter int unsigned FREQ_W  = 32
) (
    input  logic [M_W-1:0]    m_i,
    input  logic [N_W-1:0]    n_i,
    input  logic [P_W-1:0]    p_i,
    output logic [FREQ_W-1:0] freq_o
);
    logic [63:0] numer;
    logic [63:0] denom;
    logic [63:0] quot;

    always_comb begin
        numer = 64'(FIN_KHZ) * 64'(n_i);
        denom = 64'(m_i) << p_i;
        quot  = (denom == 64'd0) ? 64'd0 : (numer / denom);
        freq_o = quot[FREQ_W-1:0];
    end

endmodule

// File: rtl/synth_bringup_seq.sv
module synth_bringup_seq
    import synth_seq_pkg::*;
#(
    parameter int unsigned M_W       = 5,
    parameter int unsigned N_W       = 10,
    parameter int unsigned P_W       = 3,
    parameter int unsigned CP_W      = 4,
    parameter int unsigned MISC_W    = 12,
    parameter int unsigned CP_LSB    = 4,
    parameter int unsigned MISC_INIT = 'h90F,
    parameter int unsigned FIN_KHZ   = 12000,
    parameter int unsigned STABLE_US = 5,
    parameter int unsigned FREQ_W    = 32,
    localparam int unsigned OVR_BIT  = M_W + N_W + P_W,
    localparam int unsigned EN_BIT   = OVR_BIT + 1,
    localparam int unsigned BYP_BIT  = EN_BIT + 1,
    localparam int unsigned BASE_W   = BYP_BIT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              start,
    input  logic [M_W-1:0]    req_m,
    input  logic [N_W-1:0]    req_n,
    input  logic [P_W-1:0]    req_p,
    input  logic [CP_W-1:0]   req_cp,
    output logic [BASE_W-1:0] base_ctl,
    output logic [MISC_W-1:0] misc_ctl,
    output logic [FREQ_W-1:0] freq_khz,
    output logic              busy,
    output logic              ready,
    output logic [1:0]        status,
    output logic              invalid
);
    localparam int unsigned N_LSB = M_W;
    localparam int unsigned P_LSB = M_W + N_W;
    localparam logic [MISC_W-1:0] CP_MASK =
        MISC_W'(((64'd1 << CP_W) - 64'd1) << CP_LSB);

    typedef struct packed {
        seq_state_e        st;
        logic [BASE_W-1:0] base;
        logic [MISC_W-1:0] misc;
        logic [CP_W-1:0]   cp;
        logic              rdy;
        logic [1:0]        stat;
        logic              inv;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [M_W-1:0] cur_m;
    logic [N_W-1:0] cur_n;
    logic [P_W-1:0] cur_p;
    logic           req_match;
    logic           timer_load;
    logic           timer_done;

    assign cur_m = regs_q.base[M_W-1:0];
    assign cur_n = regs_q.base[N_LSB +: N_W];
    assign cur_p = regs_q.base[P_LSB +: P_W];

    assign req_match = (cur_m == req_m) && (cur_n == req_n) &&
                       (cur_p == req_p) && regs_q.base[EN_BIT];

    always_comb begin
        regs_d     = regs_q;
        timer_load = 1'b0;
        case (regs_q.st)
            S_IDLE: begin
                if (start) begin
                    if (regs_q.base[OVR_BIT]) begin
                        if (req_match && !regs_q.inv) begin
                            regs_d.stat = ST_MATCH;
                        end else begin
                            regs_d.stat = ST_BAD;
                            regs_d.inv  = 1'b1;
                        end
                    end else begin
                        regs_d.base                  = '0;
                        regs_d.base[M_W-1:0]         = req_m;
                        regs_d.base[N_LSB +: N_W]    = req_n;
                        regs_d.base[P_LSB +: P_W]    = req_p;
                        regs_d.base[OVR_BIT]         = 1'b1;
                        regs_d.base[BYP_BIT]         = 1'b1;
                        regs_d.cp                    = req_cp;
                        regs_d.rdy                   = 1'b0;
                        regs_d.st                    = S_MISC;
                    end
                end
            end
            S_MISC: begin
                regs_d.misc = (regs_q.misc & ~CP_MASK) |
                              (MISC_W'(regs_q.cp) << CP_LSB);
                regs_d.st   = S_EN;
            end
            S_EN: begin
                regs_d.base[EN_BIT] = 1'b1;
                regs_d.st           = S_UNBYP;
            end
            S_UNBYP: begin
                regs_d.base[BYP_BIT] = 1'b0;
                regs_d.st            = S_WAIT;
                timer_load           = 1'b1;
            end
            S_WAIT: begin
                if (timer_done) begin
                    regs_d.rdy  = 1'b1;
                    regs_d.stat = ST_FRESH;
                    regs_d.st   = S_IDLE;
                end
            end
            default: regs_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st   <= S_IDLE;
            regs_q.base <= '0;
            regs_q.misc <= MISC_W'(MISC_INIT);
            regs_q.cp   <= '0;
            regs_q.rdy  <= 1'b0;
            regs_q.stat <= ST_FRESH;
            regs_q.inv  <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    synth_stable_timer #(
        .LIMIT (STABLE_US)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_load),
        .tick_i (tick_us),
        .done_o (timer_done)
    );

    synth_freq_calc #(
        .M_W     (M_W),
        .N_W     (N_W),
        .P_W     (P_W),
        .FIN_KHZ (FIN_KHZ),
        .FREQ_W  (FREQ_W)
    ) u_freq (
        .m_i    (cur_m),
        .n_i    (cur_n),
        .p_i    (cur_p),
        .freq_o (freq_khz)
    );

    assign base_ctl = regs_q.base;
    assign misc_ctl = regs_q.misc;
    assign busy     = (regs_q.st != S_IDLE);
    assign ready    = regs_q.rdy;
    assign status   = regs_q.stat;
    assign invalid  = regs_q.inv;

    // R4: the loop is never enabled while bypass is off
    assert_bypass_at_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(base_ctl[EN_BIT]) |-> base_ctl[BYP_BIT]);

    // R4: bypass is removed only once the loop is enabled
    assert_enable_at_unbypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(base_ctl[BYP_BIT]) |-> base_ctl[EN_BIT]);

    // R3: misc bits outside the charge-pump field never move
    assert_misc_others_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(misc_ctl & ~CP_MASK));

    // R5: ready rises only at the end of the stabilization wait
    assert_ready_after_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(regs_q.st) == S_WAIT));

    // R8: the invalid flag is sticky
    assert_invalid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |=> invalid);

    // R9: a start during a sequence leaves the divider fields alone
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && regs_q.st != S_WAIT) |=>
            $stable(base_ctl[OVR_BIT-1:0]));

    // R10: ready and busy are never high together
    assert_busy_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));

endmodule

// File: tb/synth_bringup_seq_tb.sv
module synth_bringup_seq_tb;
    localparam int FIN   = 12000;
    localparam int STAB  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  req_m = '0;
    logic [9:0]  req_n = '0;
    logic [2:0]  req_p = '0;
    logic [3:0]  req_cp = '0;
    logic [20:0] base_ctl;
    logic [11:0] misc_ctl;
    logic [31:0] freq_khz;
    logic        busy, ready, invalid;
    logic [1:0]  status;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    synth_bringup_seq #(
        .FIN_KHZ   (FIN),
        .STABLE_US (STAB)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_us  (tick_us),
        .start    (start),
        .req_m    (req_m),
        .req_n    (req_n),
        .req_p    (req_p),
        .req_cp   (req_cp),
        .base_ctl (base_ctl),
        .misc_ctl (misc_ctl),
        .freq_khz (freq_khz),
        .busy     (busy),
        .ready    (ready),
        .status   (status),
        .invalid  (invalid)
    );

    always #5 clk = ~clk;

    // irregular microsecond strobe
    always @(negedge clk) begin
        cyc++;
        tick_us = ((cyc % 7) == 3) || ((cyc % 11) == 0);
    end

    // behavioural reference model
    int phase, wcnt, mm, nn, pp, cpv, byp, en, ovr, misc, rdy, stat, inv;

    task automatic model_reset();
        phase = 0; wcnt = 0; mm = 0; nn = 0; pp = 0; cpv = 0;
        byp = 0; en = 0; ovr = 0; misc = 'h90F; rdy = 0; stat = 0; inv = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            case (phase)
                0: if (start) begin
                    if (ovr == 1) begin
                        if (mm == int'(req_m) && nn == int'(req_n) &&
                            pp == int'(req_p) && en == 1 && inv == 0)
                            stat = 1;
                        else begin
                            stat = 2; inv = 1;
                        end
                    end else begin
                        mm = req_m; nn = req_n; pp = req_p; cpv = req_cp;
                        ovr = 1; byp = 1; en = 0; rdy = 0; phase = 1;
                    end
                end
                1: begin misc = (misc & ~('hF << 4)) | (cpv << 4); phase = 2; end
                2: begin en = 1; phase = 3; end
                3: begin byp = 0; wcnt = 0; phase = 4; end
                default: if (tick_us) begin
                    if (wcnt == STAB - 1) begin
                        rdy = 1; stat = 0; phase = 0;
                    end else wcnt++;
                end
            endcase
        end
    end

    function automatic longint exp_freq(int m, int n, int p);
        if (m == 0) return 0;
        return (longint'(FIN) * n) / (longint'(m) << p);
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (cmp_on && rst_n) begin
            chk("R2 base_ctl", base_ctl,
                mm | (nn << 5) | (pp << 15) | (ovr << 18) | (en << 19) | (byp << 20));
            chk("R3 misc_ctl", misc_ctl, misc);
            chk("R6 freq_khz", freq_khz, exp_freq(mm, nn, pp));
            chk("R10 busy", busy, phase != 0);
            chk("R5 ready", ready, rdy);
            chk("R7 status", status, stat);
            chk("R8 invalid", invalid, inv);
        end
    end

    task automatic do_start(int m, int n, int p, int cp);
        @(negedge clk);
        req_m = m[4:0]; req_n = n[9:0]; req_p = p[2:0]; req_cp = cp[3:0];
        start = 1'b1;
        @(posedge clk);
        #2;
        start = 1'b0;
    endtask

    task automatic wait_ready(string tag);
        int k = 0;
        while (!ready && k < 400) begin
            @(posedge clk);
            #2;
            k++;
        end
        chk(tag, ready, 1);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        cmp_on = 1'b1;
        // R1 reset values
        chk("R1 base", base_ctl, 0);
        chk("R1 misc", misc_ctl, 'h90F);
        chk("R1 busy/ready/invalid", {busy, ready, invalid}, 0);
        chk("R1 status", status, 0);
        chk("R1 freq", freq_khz, 0);

        // fresh programming, P = 1
        do_start(12, 432, 1, 8);
        chk("R2 override+bypass, no enable", base_ctl[20:18], 3'b101);
        chk("R10 busy after start", busy, 1);
        @(posedge clk); #2;
        chk("R3 cp field", misc_ctl, 'h98F);
        @(posedge clk); #2;
        chk("R4 enable with bypass", base_ctl[20:19], 2'b11);
        @(posedge clk); #2;
        chk("R4 bypass cleared", base_ctl[20:19], 2'b01);
        wait_ready("R5 ready rises");
        chk("R6 216 MHz", freq_khz, 216000);
        chk("R5 status fresh", status, 0);

        // override paths
        do_start(12, 432, 1, 3);
        chk("R7 already correct", status, 1);
        chk("R7 misc untouched", misc_ctl, 'h98F);
        do_start(12, 400, 1, 3);
        chk("R8 mismatch status", status, 2);
        chk("R8 invalid set", invalid, 1);
        chk("R8 base kept", freq_khz, 216000);
        do_start(12, 432, 1, 8);
        chk("R8 sticky error", status, 2);
        repeat (3) @(posedge clk);
        #2;

        // fresh programming, P = 2, with a start during the wait
        apply_reset();
        chk("R1 invalid cleared", invalid, 0);
        do_start(13, 600, 2, 5);
        repeat (5) @(posedge clk);
        #2;
        do_start(1, 1, 0, 0);
        chk("R9 fields unchanged", base_ctl[17:0], 13 | (600 << 5) | (2 << 15));
        chk("R9 still busy", busy, 1);
        wait_ready("R5 ready second run");
        chk("R6 truncated quotient", freq_khz, 138461);

        // M = 0
        apply_reset();
        do_start(0, 100, 0, 15);
        wait_ready("R5 ready third run");
        chk("R6 zero divider", freq_khz, 0);
        chk("R3 full cp", misc_ctl, 'h9FF);
        repeat (4) @(posedge clk);
        #2;
        finish_run();
    end

endmodule